// File: doc/BRIEF.md
# Dual-Loop Lock Detector with Power-Down

This block watches the phase-detector correction pulses of two phase-locked loops, a main loop and an auxiliary loop. It produces one lock indication from them. Time is cut into comparison windows of a fixed number of reference clock cycles. A window in which a loop's up or down pulse is active for at least `ERR_LIMIT` reference cycles shows a phase error of one reference period or more, so that window counts as out of lock for that loop.

A loop is declared locked after `LOCK_RUN` clean windows in a row. It drops out of lock at the end of the first bad window. Each loop is shut down when the shared hardware power-down pin and that loop's software power-down bit disagree (exclusive-OR). A powered-down loop loses its lock history and takes no part in the lock decision. When both loops are down, the output reads out of lock. A select input limits the output to the main loop's status.

The block is clocked by the reference clock. Every pulse input is taken to be already synchronous to that clock.

Top module: `lockdet_top`

## Requirements
- R1: While `rst_ni` is low, `lock_o` is 0, and every loop's lock history is cleared.
- R2: A loop's effective power-down output (`main_pwrdn_o`, `aux_pwrdn_o`) equals `pd_pin_i` XOR that loop's software bit, combinationally.
- R3: Comparison windows are `WIN_LEN` (default 8) reference cycles long and run back to back from reset release. A window in which the loop's up or down input is high for `ERR_LIMIT` (default 1) or more cycles is a bad window for that loop.
- R4: A powered-up loop becomes locked on the clock edge that ends its `LOCK_RUN`-th (default 4) consecutive clean window.
- R5: A locked loop becomes unlocked on the clock edge that ends its first bad window.
- R6: Any cycle in which a loop is powered down clears its lock state and window history. After power returns, the window in progress counts as that loop's first window, and `LOCK_RUN` clean window ends are needed again.
- R7: With `lock_sel_i` = 0 and exactly one loop powered down, `lock_o` follows the lock state of the powered-up loop alone. With both loops up, `lock_o` is the AND of both loop states.
- R8: With `lock_sel_i` = 0 and both loops powered down, `lock_o` is 0 in the same cycle.
- R9: With `lock_sel_i` = 1, `lock_o` is the main loop's lock state, and 0 while the main loop is powered down. The auxiliary loop has no effect on it.
- R10: Apart from power-down and select changes, `lock_o` changes only on clock edges that end a window. A bad pulse in the middle of a window leaves it unchanged until that window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| main_up_i | input | 1 | Main loop phase-detector up pulse |
| main_dn_i | input | 1 | Main loop phase-detector down pulse |
| aux_up_i | input | 1 | Auxiliary loop phase-detector up pulse |
| aux_dn_i | input | 1 | Auxiliary loop phase-detector down pulse |
| pd_pin_i | input | 1 | Hardware power-down pin, shared by both loops |
| main_pd_bit_i | input | 1 | Software power-down bit of the main loop |
| aux_pd_bit_i | input | 1 | Software power-down bit of the auxiliary loop |
| lock_sel_i | input | 1 | 0: combine both active loops; 1: main loop only |
| main_pwrdn_o | output | 1 | Effective power-down of the main loop |
| aux_pwrdn_o | output | 1 | Effective power-down of the auxiliary loop |
| lock_o | output | 1 | Lock indication |

## Verification
A corrupted clean-window run counter shows at `lock_o` as a lock that rises one or more windows too early or too late. The bench catches this at the first window edge after a quiet stretch. A stuck error flag or a misplaced window boundary shows up as a drop that comes a window late, or a drop after an isolated pulse that never arrives. Both are visible within one or two windows of the pulse. A power-down clear that fails to happen appears as a lock that returns before four full window ends have passed since power came back.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned IDX_MAIN  = 0;
  localparam int unsigned IDX_AUX   = 1;

  typedef enum logic {
    LK_COMBINED  = 1'b0,
    LK_MAIN_ONLY = 1'b1
  } lk_mode_e;

endpackage

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int unsigned WIN_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned WW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [WW-1:0] LAST = WW'(WIN_LEN - 1);

  logic [WW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + WW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lockdet_loop.sv
module lockdet_loop #(
  parameter int unsigned ERR_LIMIT = 1,
  parameter int unsigned LOCK_RUN  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic off_i,
  input  logic up_i,
  input  logic dn_i,
  output logic locked_o
);

  localparam int unsigned EW = (ERR_LIMIT > 1) ? $clog2(ERR_LIMIT + 1) : 1;
  localparam int unsigned RW = (LOCK_RUN > 1) ? $clog2(LOCK_RUN + 1) : 1;
  localparam logic [EW-1:0] ERR_MAX = EW'(ERR_LIMIT);
  localparam logic [RW-1:0] RUN_MAX = RW'(LOCK_RUN);

  logic [EW-1:0] err_q, err_d, err_sum;
  logic [RW-1:0] run_q, run_d;
  logic          locked_q, locked_d;
  logic          pulse, bad_win, upd_en;

  always_comb begin
    pulse    = up_i | dn_i;
    err_sum  = (pulse && (err_q != ERR_MAX)) ? err_q + EW'(1) : err_q;
    bad_win  = (err_sum >= ERR_MAX);
    upd_en   = off_i | tick_i | pulse;
    err_d    = err_q;
    run_d    = run_q;
    locked_d = locked_q;
    if (off_i) begin
      err_d    = '0;
      run_d    = '0;
      locked_d = 1'b0;
    end else if (tick_i) begin
      err_d = '0;
      if (bad_win) begin
        run_d    = '0;
        locked_d = 1'b0;
      end else begin
        run_d    = (run_q == RUN_MAX) ? run_q : run_q + RW'(1);
        locked_d = (run_d == RUN_MAX);
      end
    end else begin
      err_d = err_sum;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q    <= '0;
      run_q    <= '0;
      locked_q <= 1'b0;
    end else if (upd_en) begin
      err_q    <= err_d;
      run_q    <= run_d;
      locked_q <= locked_d;
    end
  end

  assign locked_o = locked_q;

endmodule

// File: rtl/lockdet_combine.sv
module lockdet_combine
  import lockdet_pkg::*;
(
  input  logic                 pd_pin_i,
  input  logic [NUM_LOOPS-1:0] pd_bit_i,
  input  logic [NUM_LOOPS-1:0] locked_i,
  input  lk_mode_e             mode_i,
  output logic [NUM_LOOPS-1:0] off_o,
  output logic                 lock_o
);

  logic [NUM_LOOPS-1:0] live;
  logic [NUM_LOOPS-1:0] pass;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_pwr
    assign off_o[g] = pd_pin_i ^ pd_bit_i[g];
    assign live[g]  = locked_i[g] & ~off_o[g];
    assign pass[g]  = off_o[g] | live[g];
  end

  always_comb begin
    unique case (mode_i)
      LK_MAIN_ONLY: lock_o = live[IDX_MAIN];
      default:      lock_o = (&pass) & ~(&off_o);
    endcase
  end

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
  import lockdet_pkg::*;
#(
  parameter int unsigned WIN_LEN   = 8,
  parameter int unsigned ERR_LIMIT = 1,
  parameter int unsigned LOCK_RUN  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_up_i,
  input  logic main_dn_i,
  input  logic aux_up_i,
  input  logic aux_dn_i,
  input  logic pd_pin_i,
  input  logic main_pd_bit_i,
  input  logic aux_pd_bit_i,
  input  logic lock_sel_i,
  output logic main_pwrdn_o,
  output logic aux_pwrdn_o,
  output logic lock_o
);

  logic                 win_tick;
  logic [NUM_LOOPS-1:0] up_v, dn_v, bit_v, off_v, locked_v;
  logic                 main_off, aux_off, main_locked, aux_locked;
  lk_mode_e             mode;

  assign up_v[IDX_MAIN]  = main_up_i;
  assign up_v[IDX_AUX]   = aux_up_i;
  assign dn_v[IDX_MAIN]  = main_dn_i;
  assign dn_v[IDX_AUX]   = aux_dn_i;
  assign bit_v[IDX_MAIN] = main_pd_bit_i;
  assign bit_v[IDX_AUX]  = aux_pd_bit_i;
  assign mode            = lk_mode_e'(lock_sel_i);

  lockdet_window #(
    .WIN_LEN (WIN_LEN)
  ) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (win_tick)
  );

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    lockdet_loop #(
      .ERR_LIMIT (ERR_LIMIT),
      .LOCK_RUN  (LOCK_RUN)
    ) u_loop (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (win_tick),
      .off_i    (off_v[g]),
      .up_i     (up_v[g]),
      .dn_i     (dn_v[g]),
      .locked_o (locked_v[g])
    );
  end

  lockdet_combine u_comb (
    .pd_pin_i (pd_pin_i),
    .pd_bit_i (bit_v),
    .locked_i (locked_v),
    .mode_i   (mode),
    .off_o    (off_v),
    .lock_o   (lock_o)
  );

  assign main_off     = off_v[IDX_MAIN];
  assign aux_off      = off_v[IDX_AUX];
  assign main_locked  = locked_v[IDX_MAIN];
  assign aux_locked   = locked_v[IDX_AUX];
  assign main_pwrdn_o = main_off;
  assign aux_pwrdn_o  = aux_off;

endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic main_off,
  input logic aux_off,
  input logic main_locked,
  input logic aux_locked,
  input logic lock_sel_i,
  input logic lock_o
);

  p_both_off_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_sel_i && main_off && aux_off) |-> !lock_o);

  p_main_only_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_sel_i && main_off) |-> !lock_o);

  p_main_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_off |=> !main_locked);

  p_aux_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_off |=> !aux_locked);

  p_main_rise_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_locked) |-> $past(tick));

  p_aux_rise_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aux_locked) |-> $past(tick));

  p_main_fall_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(main_locked) |-> ($past(tick) || $past(main_off)));

  p_lock_source_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (main_locked || aux_locked));

endmodule

bind lockdet_top lockdet_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick        (win_tick),
  .main_off    (main_off),
  .aux_off     (aux_off),
  .main_locked (main_locked),
  .aux_locked  (aux_locked),
  .lock_sel_i  (lock_sel_i),
  .lock_o      (lock_o)
);

// File: tb/sim_lockdet_top.sv
`timescale 1ns/1ps
module sim_lockdet_top;

  localparam int WIN  = 8;
  localparam int RUNS = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic up_m, dn_m, up_a, dn_a, pd_pin, pb_m, pb_a, sel;
  logic pwr_m, pwr_a, lock;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit cont_on = 1'b0;

  // bench model state
  int m_pos;
  bit m_bad [2];
  int m_run [2];
  bit m_lk  [2];
  bit prev_exp;

  always #4 clk = ~clk;

  lockdet_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .main_up_i(up_m), .main_dn_i(dn_m), .aux_up_i(up_a), .aux_dn_i(dn_a),
    .pd_pin_i(pd_pin), .main_pd_bit_i(pb_m), .aux_pd_bit_i(pb_a),
    .lock_sel_i(sel), .main_pwrdn_o(pwr_m), .aux_pwrdn_o(pwr_a), .lock_o(lock)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_lock();
    bit om, oa;
    om = pd_pin ^ pb_m;
    oa = pd_pin ^ pb_a;
    if (sel) return m_lk[0] && !om;
    if (om && oa) return 1'b0;
    return (om || m_lk[0]) && (oa || m_lk[1]);
  endfunction

  // Model written from R3..R6
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0;
      for (int i = 0; i < 2; i++) begin
        m_bad[i] = 1'b0; m_run[i] = 0; m_lk[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit off, act;
        off = pd_pin ^ ((i == 0) ? pb_m : pb_a);
        act = (i == 0) ? (up_m | dn_m) : (up_a | dn_a);
        if (off) begin
          m_bad[i] = 1'b0; m_run[i] = 0; m_lk[i] = 1'b0;
        end else if (m_pos == WIN - 1) begin
          if (m_bad[i] || act) begin
            m_run[i] = 0; m_lk[i] = 1'b0;
          end else begin
            if (m_run[i] < RUNS) m_run[i] = m_run[i] + 1;
            m_lk[i] = (m_run[i] == RUNS);
          end
          m_bad[i] = 1'b0;
        end else if (act) begin
          m_bad[i] = 1'b1;
        end
      end
      m_pos = (m_pos == WIN - 1) ? 0 : m_pos + 1;
    end
  end

  // Every-cycle comparison, tagged by situation
  always @(negedge clk) begin
    if (rst_n && cont_on) begin
      bit e, om, oa;
      e  = exp_lock();
      om = pd_pin ^ pb_m;
      oa = pd_pin ^ pb_a;
      if (sel)                 chk("R9", lock, e);
      else if (om && oa)       chk("R8", lock, e);
      else if (om || oa)       chk("R7", lock, e);
      else if (e && !prev_exp) chk("R4", lock, e);
      else if (!e && prev_exp) chk("R5", lock, e);
      else                     chk("R10", lock, e);
      prev_exp = e;
    end
  end

  task automatic drive(input logic pin, input logic bm, input logic ba);
    @(posedge clk); #1;
    pd_pin = pin; pb_m = bm; pb_a = ba;
  endtask

  task automatic wait_boundary();
    @(negedge clk);
    while (m_pos != 0) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5417));
    rst_n = 1'b0; prev_exp = 1'b0;
    up_m = 0; dn_m = 0; up_a = 0; dn_a = 0;
    pd_pin = 0; pb_m = 0; pb_a = 0; sel = 0;
    repeat (3) @(negedge clk);
    chk("R1", lock, 1'b0);
    rst_n = 1'b1;
    cont_on = 1'b1;

    // R2: every combination of pin and bits
    for (int c = 0; c < 8; c++) begin
      drive(c[2], c[1], c[0]);
      @(negedge clk);
      chk("R2", pwr_m, c[2] ^ c[1]);
      chk("R2", pwr_a, c[2] ^ c[0]);
    end

    // R4: clear both, then release just after a window edge
    drive(1, 0, 0);
    wait_boundary();
    drive(0, 0, 0);
    repeat (3) wait_boundary();
    chk("R4", lock, 1'b0);
    wait_boundary();
    chk("R4", lock, 1'b1);

    // R10 then R3: one-cycle main pulse mid-window
    wait_boundary();
    @(posedge clk); #1; dn_m = 1;
    @(posedge clk); #1; dn_m = 0;
    @(negedge clk);
    chk("R10", lock, 1'b1);
    wait_boundary();
    chk("R3", lock, 1'b0);

    // R7: main off, aux still locked
    drive(0, 1, 0);
    @(negedge clk);
    chk("R7", lock, 1'b1);
    // pin high with main bit high: main up (unlocked), aux off
    drive(1, 1, 0);
    @(negedge clk);
    chk("R7", lock, 1'b0);
    // R8: both off
    drive(1, 0, 0);
    @(negedge clk);
    chk("R8", lock, 1'b0);

    // relock both
    drive(0, 0, 0);
    repeat (6) wait_boundary();
    chk("R4", lock, 1'b1);

    // R9: main only, aux disturbance has no effect
    sel = 1;
    drive(0, 0, 1);
    @(negedge clk);
    chk("R9", lock, 1'b1);
    drive(0, 1, 0);
    @(negedge clk);
    chk("R9", lock, 1'b0);
    drive(0, 0, 0);
    sel = 0;
    repeat (6) wait_boundary();

    // R6: main off for one cycle right after an edge
    wait_boundary();
    drive(0, 1, 0);
    drive(0, 0, 0);
    repeat (3) wait_boundary();
    chk("R6", lock, 1'b0);
    wait_boundary();
    chk("R6", lock, 1'b1);

    // random phase
    for (int blk = 0; blk < 30; blk++) begin
      int rate;
      case ($urandom % 3)
        0: rate = 12;
        1: rate = 80;
        default: rate = 2000;
      endcase
      for (int k = 0; k < 500; k++) begin
        @(posedge clk); #1;
        up_m = ($urandom % rate) == 0;
        dn_m = ($urandom % rate) == 0;
        up_a = ($urandom % rate) == 0;
        dn_a = ($urandom % rate) == 0;
        if (($urandom % 400) == 0) pb_m = ~pb_m;
        if (($urandom % 400) == 0) pb_a = ~pb_a;
        if (($urandom % 900) == 0) pd_pin = ~pd_pin;
        if (($urandom % 1500) == 0) sel = ~sel;
      end
    end

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule